// File: doc/BRIEF.md
# Half-Duplex Transmit Retry Controller

This block moves one frame at a time from a transmit frame store onto a byte-wide MAC transmit path, one byte per clock. It waits for the carrier to stay quiet for a full inter-frame gap before it starts. It pads short frames with data, and it extends frames that are still short with non-data filler symbols up to a minimum collision window. In half duplex it watches for collisions and retries the frame after a truncated binary exponential backoff. A frame that collides too often, or that is hit by a late collision while late retry is off, is dropped.

Every frame ends with a one-cycle status pulse and a pop of the frame store. Software settings arrive on static configuration inputs: enable, pad, duplex, late-collision retry, retry limit and collision window. A pause-request flag is also provided. Once set, it launches a pause frame in the gap between two frames, and it clears itself when the pause frame has gone out.

The frame store shows the frame at its head: a length, and the byte at the offset the block requests. Because the block reads by offset, it can replay a frame after a collision without rewinding the store.

Top module: `hdx_tx_retry`

## Requirements
- R1: A new frame starts only while `cfgEnable` is 1. Clearing `cfgEnable` during a frame lets that frame, including its retries, finish. The next queued frame then waits until `cfgEnable` is 1 again.
- R2: With `cfgPadShort`=1, a frame shorter than 64 bytes goes out as 64 data bytes (`txIsFill`=0). The bytes past the stored length are 0x00.
- R3: In half duplex, a frame gets at most `cfgRetryLimit`+1 attempts. A collision on the last allowed attempt ends the frame with `statusCode`=2 (excess collisions).
- R4: After collision number n of a frame, the block waits s·SLOT_BYTES clocks before the inter-frame-gap wait begins again, where 0 ≤ s ≤ 2^min(n,10)−1. The value s comes from an internal LFSR. Counting from the clock in which the collision is seen, the next attempt starts 14 + s·SLOT_BYTES clocks later when the carrier is idle.
- R5: In either duplex mode, if the frame is still shorter than `cfgCollDist`+1 bytes after data padding, the block extends it with bytes marked `txIsFill`=1 (data 0x00) to exactly `cfgCollDist`+1 bytes. Filler bytes only follow data bytes.
- R6: A collision seen on byte index ≥ `cfgCollDist` (index 0 is the first byte) is late. With `cfgLateRetry`=0, a late collision ends the frame with `statusCode`=3. With `cfgLateRetry`=1, it is retried like an early collision.
- R7: With `cfgFullDuplex`=1, `collision` is ignored. Every frame is sent once, in full, and ends with `statusCode`=1.
- R8: A `pauseSet` pulse sets `pausePending`. Between frames, a pending request is served ahead of any queued frame. It waits out the inter-frame gap and then gives a one-cycle `pauseStart`. `pausePending` clears on `pauseDone`. A frame in progress is never interrupted by a pause request.
- R9: An attempt starts only after `carrierSense` has been 0 for 12 consecutive clocks. The first byte appears in the 13th clock, and any carrier activity restarts the count.
- R10: Each frame ends with a one-cycle `statusValid` and `fifoPop` in the clock after its last byte or its final collision. The code is 1 for sent, 2 for excess collisions, and 3 for late collision.
- R11: During and right after reset, `txValid`, `statusValid`, `fifoPop`, `pauseStart` and `pausePending` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgEnable | input | 1 | Allow new frames to start |
| cfgPadShort | input | 1 | Pad frames shorter than 64 bytes with data |
| cfgFullDuplex | input | 1 | 1 = full duplex, no collision handling |
| cfgLateRetry | input | 1 | Retry frames hit by a late collision |
| cfgRetryLimit | input | CT_W | Retries allowed after the first attempt |
| cfgCollDist | input | CD_W | Collision window in byte times |
| pauseSet | input | 1 | Pulse that raises a pause request |
| pauseDone | input | 1 | Pause frame has been sent |
| pauseStart | output | 1 | One-cycle launch of a pause frame |
| pausePending | output | 1 | Pause request outstanding |
| fifoValid | input | 1 | A frame is at the store head; must drop in the cycle `fifoPop` is high if no frame follows |
| fifoFrameLen | input | LEN_W | Length in bytes of the head frame (≥1) |
| fifoData | input | 8 | Head-frame byte at offset `rdAddr` |
| rdAddr | output | LEN_W | Byte offset being read |
| fifoPop | output | 1 | Remove head frame |
| carrierSense | input | 1 | Medium busy |
| collision | input | 1 | Collision seen on the medium |
| txValid | output | 1 | A byte is being transmitted |
| txData | output | 8 | Transmit byte |
| txIsFill | output | 1 | Current byte is a filler symbol |
| statusValid | output | 1 | Frame result strobe |
| statusCode | output | 2 | 1 sent, 2 excess collisions, 3 late collision |

## Verification
The bench goes after the byte exactly at the collision window, where an off-by-one compare would drop a frame that should be retried, or retry one that should be dropped. It drives limits of 0 and 3 with a collision on every attempt. A block that counts the first attempt as a retry gives one attempt too few or too many. It measures every backoff gap up to eleven retries. An exponent that grows past ten, or a slot count that is not a whole multiple of the slot length, shows up as a gap outside the allowed set. Enable is dropped mid-frame to catch a truncated frame or an early start of the next one. A pause request is raised while a frame waits, to catch a frame sent ahead of the pause.

// File: rtl/hdx_tx_pkg.sv
package hdx_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEFER,
    ST_SEND,
    ST_BACKOFF,
    ST_PAUSE
  } txState_t;

  typedef enum logic [1:0] {
    TXS_NONE   = 2'd0,
    TXS_SENT   = 2'd1,
    TXS_EXCESS = 2'd2,
    TXS_LATE   = 2'd3
  } txStatus_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchLen;
    logic clrByte;
    logic incByte;
    logic clrDefer;
    logic incDefer;
    logic clrRetry;
    logic loadBackoff;
  } dpCtrl_t;

  // conditions reported back by the datapath
  typedef struct packed {
    logic lastByte;
    logic isLate;
    logic deferDone;
    logic backoffDone;
    logic retryAtLimit;
  } dpFlags_t;

endpackage

// File: rtl/hdx_tx_datapath.sv
module hdx_tx_datapath
  import hdx_tx_pkg::*;
#(
  parameter int LEN_W       = 11,
  parameter int CD_W        = 10,
  parameter int CT_W        = 4,
  parameter int SLOT_BYTES  = 64,
  parameter int IFG_BYTES   = 12,
  parameter int MIN_FRAME   = 64,
  parameter int BACKOFF_CAP = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrl_t          ctrl,
  input  logic             inSend,
  input  logic             inBackoff,
  input  logic [LEN_W-1:0] fifoFrameLen,
  input  logic [7:0]       fifoData,
  input  logic             cfgPadShort,
  input  logic [CD_W-1:0]  cfgCollDist,
  input  logic [CT_W-1:0]  cfgRetryLimit,
  input  logic             carrierSense,
  output dpFlags_t         flags,
  output logic [LEN_W-1:0] rdAddr,
  output logic [7:0]       txData,
  output logic             txIsFill
);

  localparam int SLOT_W = $clog2(SLOT_BYTES + 1);
  localparam int DEF_W  = $clog2(IFG_BYTES + 1);
  localparam int LFSR_W = 16;
  localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(MIN_FRAME);

  logic [LEN_W-1:0]       frameLen;
  logic [LEN_W-1:0]       byteCnt;
  logic [DEF_W-1:0]       deferCnt;
  logic [CT_W-1:0]        retryCnt;
  logic [BACKOFF_CAP-1:0] backSlots;
  logic [SLOT_W-1:0]      slotCnt;
  logic [LFSR_W-1:0]      lfsr;
  logic [LEN_W-1:0]       dataLen;
  logic [LEN_W-1:0]       totalLen;
  logic [LEN_W-1:0]       minLen;
  logic [CT_W-1:0]        nextRetry;

  // window of 2^min(n,cap) slots, as a mask
  function automatic logic [BACKOFF_CAP-1:0] rangeMask(input logic [CT_W-1:0] n);
    int k;
    k = (int'(n) > BACKOFF_CAP) ? BACKOFF_CAP : int'(n);
    return BACKOFF_CAP'((1 << k) - 1);
  endfunction

  assign nextRetry = retryCnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameLen  <= '0;
      byteCnt   <= '0;
      deferCnt  <= '0;
      retryCnt  <= '0;
      backSlots <= '0;
      slotCnt   <= '0;
      lfsr      <= 16'hACE1;
    end else begin
      lfsr <= {lfsr[LFSR_W-2:0], lfsr[15] ^ lfsr[14] ^ lfsr[12] ^ lfsr[3]};

      if (ctrl.latchLen) frameLen <= fifoFrameLen;

      if (ctrl.clrByte)      byteCnt <= '0;
      else if (ctrl.incByte) byteCnt <= byteCnt + 1'b1;

      if (ctrl.clrDefer)      deferCnt <= '0;
      else if (ctrl.incDefer) deferCnt <= deferCnt + 1'b1;

      if (ctrl.clrRetry)         retryCnt <= '0;
      else if (ctrl.loadBackoff) retryCnt <= nextRetry;

      if (ctrl.loadBackoff) begin
        backSlots <= lfsr[BACKOFF_CAP-1:0] & rangeMask(nextRetry);
        slotCnt   <= '0;
      end else if (inBackoff && backSlots != '0) begin
        if (slotCnt == SLOT_W'(SLOT_BYTES - 1)) begin
          slotCnt   <= '0;
          backSlots <= backSlots - 1'b1;
        end else begin
          slotCnt <= slotCnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    dataLen  = (cfgPadShort && frameLen < MIN_LEN) ? MIN_LEN : frameLen;
    minLen   = LEN_W'(cfgCollDist) + 1'b1;
    totalLen = (dataLen > minLen) ? dataLen : minLen;

    flags.lastByte     = (byteCnt == totalLen - 1'b1);
    flags.isLate       = (byteCnt >= LEN_W'(cfgCollDist));
    flags.deferDone    = (deferCnt == DEF_W'(IFG_BYTES - 1)) && !carrierSense;
    flags.backoffDone  = (backSlots == '0);
    flags.retryAtLimit = (retryCnt >= cfgRetryLimit);

    rdAddr   = byteCnt;
    txData   = (byteCnt < frameLen) ? fifoData : 8'h00;
    txIsFill = inSend && (byteCnt >= dataLen);
  end

  // filler never precedes a data byte within one attempt
  assert_fill_tail_R5 : assert property (@(posedge clk) disable iff (!rstN)
    (inSend && txIsFill) |=> (!inSend || txIsFill));

  // drawn backoff fits the window of the retry just counted
  assert_backoff_range_R4 : assert property (@(posedge clk) disable iff (!rstN)
    ctrl.loadBackoff |=> ((backSlots & ~rangeMask(retryCnt)) == '0));

endmodule

// File: rtl/hdx_tx_control.sv
module hdx_tx_control
  import hdx_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cfgEnable,
  input  logic      cfgFullDuplex,
  input  logic      cfgLateRetry,
  input  logic      fifoValid,
  input  logic      carrierSense,
  input  logic      collision,
  input  logic      pauseSet,
  input  logic      pauseDone,
  input  dpFlags_t  flags,
  output dpCtrl_t   ctrl,
  output logic      inSend,
  output logic      inBackoff,
  output logic      txValid,
  output logic      fifoPop,
  output logic      statusValid,
  output logic [1:0] statusCode,
  output logic      pauseStart,
  output logic      pausePending
);

  txState_t  state, stateNext;
  logic      doPause, doPauseNext;
  logic      finish;
  txStatus_t finishCode;
  logic      launchPause;

  always_comb begin
    ctrl        = '0;
    stateNext   = state;
    doPauseNext = doPause;
    finish      = 1'b0;
    finishCode  = TXS_NONE;
    launchPause = 1'b0;

    unique case (state)
      ST_IDLE: begin
        if (pausePending) begin
          stateNext     = ST_DEFER;
          doPauseNext   = 1'b1;
          ctrl.clrDefer = 1'b1;
        end else if (cfgEnable && fifoValid) begin
          stateNext     = ST_DEFER;
          doPauseNext   = 1'b0;
          ctrl.latchLen = 1'b1;
          ctrl.clrByte  = 1'b1;
          ctrl.clrRetry = 1'b1;
          ctrl.clrDefer = 1'b1;
        end
      end
      ST_DEFER: begin
        if (carrierSense) ctrl.clrDefer = 1'b1;
        else              ctrl.incDefer = 1'b1;
        if (flags.deferDone) begin
          ctrl.clrByte = 1'b1;
          if (doPause) begin
            stateNext   = ST_PAUSE;
            launchPause = 1'b1;
          end else begin
            stateNext = ST_SEND;
          end
        end
      end
      ST_SEND: begin
        ctrl.incByte = 1'b1;
        if (collision && !cfgFullDuplex) begin
          if (flags.isLate && !cfgLateRetry) begin
            finish     = 1'b1;
            finishCode = TXS_LATE;
            stateNext  = ST_IDLE;
          end else if (flags.retryAtLimit) begin
            finish     = 1'b1;
            finishCode = TXS_EXCESS;
            stateNext  = ST_IDLE;
          end else begin
            ctrl.loadBackoff = 1'b1;
            stateNext        = ST_BACKOFF;
          end
        end else if (flags.lastByte) begin
          finish     = 1'b1;
          finishCode = TXS_SENT;
          stateNext  = ST_IDLE;
        end
      end
      ST_BACKOFF: begin
        if (flags.backoffDone) begin
          ctrl.clrDefer = 1'b1;
          stateNext     = ST_DEFER;
        end
      end
      ST_PAUSE: begin
        if (pauseDone) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      doPause      <= 1'b0;
      fifoPop      <= 1'b0;
      statusValid  <= 1'b0;
      statusCode   <= TXS_NONE;
      pauseStart   <= 1'b0;
      pausePending <= 1'b0;
    end else begin
      state        <= stateNext;
      doPause      <= doPauseNext;
      fifoPop      <= finish;
      statusValid  <= finish;
      statusCode   <= finish ? finishCode : TXS_NONE;
      pauseStart   <= launchPause;
      pausePending <= pauseSet | (pausePending & !(state == ST_PAUSE && pauseDone));
    end
  end

  assign inSend    = (state == ST_SEND);
  assign inBackoff = (state == ST_BACKOFF);
  assign txValid   = inSend;

  assert_pause_oneshot_R8 : assert property (@(posedge clk) disable iff (!rstN)
    pauseStart |=> !pauseStart);

  assert_defer_idle_R9 : assert property (@(posedge clk) disable iff (!rstN)
    $rose(txValid) |-> $past(!carrierSense));

  assert_status_pulse_R10 : assert property (@(posedge clk) disable iff (!rstN)
    statusValid |=> !statusValid);

  assert_fd_sent_R7 : assert property (@(posedge clk) disable iff (!rstN)
    (statusValid && cfgFullDuplex) |-> (statusCode == TXS_SENT));

endmodule

// File: rtl/hdx_tx_retry.sv
module hdx_tx_retry
  import hdx_tx_pkg::*;
#(
  parameter int LEN_W       = 11,
  parameter int CD_W        = 10,
  parameter int CT_W        = 4,
  parameter int SLOT_BYTES  = 64,
  parameter int IFG_BYTES   = 12,
  parameter int MIN_FRAME   = 64,
  parameter int BACKOFF_CAP = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgEnable,
  input  logic             cfgPadShort,
  input  logic             cfgFullDuplex,
  input  logic             cfgLateRetry,
  input  logic [CT_W-1:0]  cfgRetryLimit,
  input  logic [CD_W-1:0]  cfgCollDist,
  input  logic             pauseSet,
  input  logic             pauseDone,
  output logic             pauseStart,
  output logic             pausePending,
  input  logic             fifoValid,
  input  logic [LEN_W-1:0] fifoFrameLen,
  input  logic [7:0]       fifoData,
  output logic [LEN_W-1:0] rdAddr,
  output logic             fifoPop,
  input  logic             carrierSense,
  input  logic             collision,
  output logic             txValid,
  output logic [7:0]       txData,
  output logic             txIsFill,
  output logic             statusValid,
  output logic [1:0]       statusCode
);

  dpCtrl_t  ctrl;
  dpFlags_t flags;
  logic     inSend;
  logic     inBackoff;

  hdx_tx_control control_i (
    .clk          (clk),
    .rstN         (rstN),
    .cfgEnable    (cfgEnable),
    .cfgFullDuplex(cfgFullDuplex),
    .cfgLateRetry (cfgLateRetry),
    .fifoValid    (fifoValid),
    .carrierSense (carrierSense),
    .collision    (collision),
    .pauseSet     (pauseSet),
    .pauseDone    (pauseDone),
    .flags        (flags),
    .ctrl         (ctrl),
    .inSend       (inSend),
    .inBackoff    (inBackoff),
    .txValid      (txValid),
    .fifoPop      (fifoPop),
    .statusValid  (statusValid),
    .statusCode   (statusCode),
    .pauseStart   (pauseStart),
    .pausePending (pausePending)
  );

  hdx_tx_datapath #(
    .LEN_W      (LEN_W),
    .CD_W       (CD_W),
    .CT_W       (CT_W),
    .SLOT_BYTES (SLOT_BYTES),
    .IFG_BYTES  (IFG_BYTES),
    .MIN_FRAME  (MIN_FRAME),
    .BACKOFF_CAP(BACKOFF_CAP)
  ) datapath_i (
    .clk          (clk),
    .rstN         (rstN),
    .ctrl         (ctrl),
    .inSend       (inSend),
    .inBackoff    (inBackoff),
    .fifoFrameLen (fifoFrameLen),
    .fifoData     (fifoData),
    .cfgPadShort  (cfgPadShort),
    .cfgCollDist  (cfgCollDist),
    .cfgRetryLimit(cfgRetryLimit),
    .carrierSense (carrierSense),
    .flags        (flags),
    .rdAddr       (rdAddr),
    .txData       (txData),
    .txIsFill     (txIsFill)
  );

endmodule

// File: tb/hdx_tx_retry_tb_top.sv
module hdx_tx_retry_tb_top;

  localparam int LEN_W = 11;
  localparam int CD_W  = 10;
  localparam int CT_W  = 4;
  localparam int SLOT  = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             cfgEnable = 1'b0, cfgPadShort = 1'b0, cfgFullDuplex = 1'b0, cfgLateRetry = 1'b0;
  logic [CT_W-1:0]  cfgRetryLimit = '0;
  logic [CD_W-1:0]  cfgCollDist = '0;
  logic             pauseSet = 1'b0, pauseDone = 1'b0;
  logic             pauseStart, pausePending;
  logic             fifoValid;
  logic [LEN_W-1:0] fifoFrameLen = '0;
  logic [7:0]       fifoData;
  logic [LEN_W-1:0] rdAddr;
  logic             fifoPop;
  logic             carrierSense = 1'b0, collision = 1'b0;
  logic             txValid, txIsFill, statusValid;
  logic [7:0]       txData;
  logic [1:0]       statusCode;

  logic [7:0] mem [0:255];
  int queued = 0;
  assign fifoValid = (queued > 0);
  assign fifoData  = mem[rdAddr[7:0]];

  hdx_tx_retry #(.SLOT_BYTES(SLOT)) dut_i (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgPadShort(cfgPadShort),
    .cfgFullDuplex(cfgFullDuplex), .cfgLateRetry(cfgLateRetry),
    .cfgRetryLimit(cfgRetryLimit), .cfgCollDist(cfgCollDist),
    .pauseSet(pauseSet), .pauseDone(pauseDone), .pauseStart(pauseStart),
    .pausePending(pausePending), .fifoValid(fifoValid), .fifoFrameLen(fifoFrameLen),
    .fifoData(fifoData), .rdAddr(rdAddr), .fifoPop(fifoPop),
    .carrierSense(carrierSense), .collision(collision), .txValid(txValid),
    .txData(txData), .txIsFill(txIsFill), .statusValid(statusValid),
    .statusCode(statusCode)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChecks = 0, nFail = 0;
  bit done = 0;

  // monitor state
  int attempts = 0, recCnt = 0, statusCnt = 0, popCnt = 0, pauseCnt = 0;
  int lastCode = 0, attemptsAtPause = -1, pauseWait = 0;
  bit prevValid = 0, collOn = 0;
  int collAt = 0, collUpto = 0;
  int recData [0:2047];
  int recFill [0:2047];
  int startCyc [0:63];
  int collCyc [0:63];

  always @(negedge clk) begin
    pauseDone = 1'b0;
    if (pauseWait > 0) begin
      pauseWait--;
      if (pauseWait == 0) pauseDone = 1'b1;
    end
    if (pauseStart) begin
      pauseCnt++;
      attemptsAtPause = attempts;
      pauseWait = 5;
    end
    if (txValid) begin
      if (!prevValid) begin
        attempts++;
        startCyc[attempts] = cyc;
        recCnt = 0;
      end
      recData[recCnt] = int'(txData);
      recFill[recCnt] = int'(txIsFill);
      if (collOn && attempts <= collUpto && recCnt == collAt) begin
        collision = 1'b1;
        collCyc[attempts] = cyc;
      end else begin
        collision = 1'b0;
      end
      recCnt++;
    end else begin
      collision = 1'b0;
    end
    prevValid = txValid;
    if (statusValid) begin
      statusCnt++;
      lastCode = int'(statusCode);
    end
    if (fifoPop) begin
      popCnt++;
      if (queued > 0) queued--;
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(bit ok, string req, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clearRec();
    attempts = 0; recCnt = 0; statusCnt = 0; popCnt = 0; pauseCnt = 0;
    lastCode = 0; attemptsAtPause = -1; collOn = 0; collAt = 0; collUpto = 0;
  endtask

  task automatic setCfg(bit en, bit pad, bit fd, bit late, int lim, int cd, int len);
    cfgEnable = en; cfgPadShort = pad; cfgFullDuplex = fd; cfgLateRetry = late;
    cfgRetryLimit = CT_W'(lim); cfgCollDist = CD_W'(cd); fifoFrameLen = LEN_W'(len);
  endtask

  task automatic waitStatus(int n, int lim, string req);
    int w;
    w = 0;
    while (statusCnt < n && w < lim) begin
      step(1);
      w++;
    end
    step(3);
    check(statusCnt >= n, req, "status count", statusCnt, n);
  endtask

  task automatic checkBytes(string req, int len, bit pad, int cd);
    int dl, tot, bad, expD, expF;
    dl  = (pad && len < 64) ? 64 : len;
    tot = (dl > cd + 1) ? dl : cd + 1;
    bad = 0;
    check(recCnt == tot, req, "byte count", recCnt, tot);
    for (int i = 0; i < recCnt; i++) begin
      expD = (i < len) ? int'(mem[i]) : 0;
      expF = (i >= dl) ? 1 : 0;
      if (recData[i] != expD || recFill[i] != expF) bad++;
    end
    check(bad == 0, req, "byte mismatches", bad, 0);
  endtask

  // R11: reset values
  task automatic testReset();
    step(3);
    check(!txValid && !statusValid && !fifoPop && !pauseStart && !pausePending,
          "R11", "outputs in reset", int'(txValid | statusValid | pausePending), 0);
    rstN = 1'b1;
    step(2);
    check(!txValid && !pausePending, "R11", "outputs after reset",
          int'(txValid | pausePending), 0);
  endtask

  // R10/R7: plain full-duplex send
  task automatic testPlain();
    clearRec();
    setCfg(1, 1, 1, 0, 15, 20, 70);
    queued = 1;
    waitStatus(1, 400, "R10");
    check(lastCode == 1, "R10", "status code", lastCode, 1);
    check(popCnt == 1, "R10", "pop count", popCnt, 1);
    checkBytes("R10", 70, 1, 20);
  endtask

  // R2: pad with data to 64
  task automatic testPad();
    clearRec();
    setCfg(1, 1, 1, 0, 15, 20, 10);
    queued = 1;
    waitStatus(1, 400, "R2");
    checkBytes("R2", 10, 1, 20);
  endtask

  // R5: filler to collDist+1 in both duplex modes
  task automatic testFill(bit fd);
    clearRec();
    setCfg(1, 0, fd, 0, 15, 30, 10);
    queued = 1;
    waitStatus(1, 400, "R5");
    checkBytes("R5", 10, 0, 30);
    check(lastCode == 1, "R5", "status code", lastCode, 1);
  endtask

  // R9: carrier gating and 12-clock gap
  task automatic testDefer();
    int lowCyc;
    clearRec();
    setCfg(1, 1, 1, 0, 15, 20, 70);
    carrierSense = 1'b1;
    queued = 1;
    step(40);
    check(attempts == 0, "R9", "start while carrier busy", attempts, 0);
    carrierSense = 1'b0;
    step(5);
    carrierSense = 1'b1;
    step(1);
    carrierSense = 1'b0;
    lowCyc = cyc;
    waitStatus(1, 400, "R9");
    check(startCyc[1] - lowCyc == 12, "R9", "gap after carrier", startCyc[1] - lowCyc, 12);
  endtask

  // R1: enable dropped mid-frame
  task automatic testEnable();
    int w;
    clearRec();
    setCfg(1, 1, 1, 0, 15, 20, 80);
    queued = 2;
    w = 0;
    while (attempts == 0 && w < 200) begin step(1); w++; end
    cfgEnable = 1'b0;
    waitStatus(1, 400, "R1");
    checkBytes("R1", 80, 1, 20);
    step(60);
    check(attempts == 1, "R1", "frame started while disabled", attempts, 1);
    cfgEnable = 1'b1;
    waitStatus(2, 400, "R1");
    check(attempts == 2, "R1", "frame after re-enable", attempts, 2);
  endtask

  // R4: early collisions retried with bounded backoff
  task automatic testRetry();
    int gap, k, s;
    clearRec();
    setCfg(1, 1, 0, 0, 15, 20, 40);
    collOn = 1; collAt = 3; collUpto = 2;
    queued = 1;
    waitStatus(1, 2000, "R4");
    check(attempts == 3, "R4", "attempts", attempts, 3);
    check(lastCode == 1, "R4", "status code", lastCode, 1);
    checkBytes("R4", 40, 1, 20);
    for (int n = 1; n <= 2; n++) begin
      gap = startCyc[n + 1] - collCyc[n];
      k = (n < 10) ? n : 10;
      s = (gap - 14) / SLOT;
      check(gap >= 14 && (gap - 14) % SLOT == 0 && s <= (1 << k) - 1,
            "R4", "backoff gap", gap, 14 + s * SLOT);
    end
  endtask

  // R3: retry limit
  task automatic testExcess(int lim);
    clearRec();
    setCfg(1, 1, 0, 0, lim, 20, 40);
    collOn = 1; collAt = 2; collUpto = 99;
    queued = 1;
    waitStatus(1, 5000, "R3");
    check(attempts == lim + 1, "R3", "attempts", attempts, lim + 1);
    check(lastCode == 2, "R3", "status code", lastCode, 2);
    check(popCnt == 1, "R3", "pop count", popCnt, 1);
  endtask

  // R6: late collision boundary and late retry
  task automatic testLate(bit lateRetry, int at, int expAttempts, int expCode);
    clearRec();
    setCfg(1, 1, 0, lateRetry, 15, 20, 60);
    collOn = 1; collAt = at; collUpto = 1;
    queued = 1;
    waitStatus(1, 2000, "R6");
    check(attempts == expAttempts, "R6", "attempts", attempts, expAttempts);
    check(lastCode == expCode, "R6", "status code", lastCode, expCode);
  endtask

  // R7: full duplex ignores collisions
  task automatic testFullDuplex();
    clearRec();
    setCfg(1, 1, 1, 0, 0, 20, 50);
    collOn = 1; collAt = 5; collUpto = 99;
    queued = 1;
    waitStatus(1, 400, "R7");
    check(attempts == 1, "R7", "attempts", attempts, 1);
    check(lastCode == 1, "R7", "status code", lastCode, 1);
    checkBytes("R7", 50, 1, 20);
  endtask

  // R8: pause request served ahead of queued frame
  task automatic testPause();
    clearRec();
    setCfg(0, 1, 1, 0, 15, 20, 70);
    queued = 1;
    step(5);
    pauseSet = 1'b1;
    step(1);
    pauseSet = 1'b0;
    check(pausePending == 1'b1, "R8", "pending after set", int'(pausePending), 1);
    cfgEnable = 1'b1;
    waitStatus(1, 600, "R8");
    check(pauseCnt == 1, "R8", "pause launches", pauseCnt, 1);
    check(attemptsAtPause == 0, "R8", "frames before pause", attemptsAtPause, 0);
    check(pausePending == 1'b0, "R8", "pending after done", int'(pausePending), 0);
    check(lastCode == 1, "R8", "frame after pause", lastCode, 1);
  endtask

  // R4: exponent capped at 10 over many retries
  task automatic testCap();
    int gap, k, s, bad;
    clearRec();
    setCfg(1, 1, 0, 0, 11, 20, 40);
    collOn = 1; collAt = 1; collUpto = 99;
    queued = 1;
    waitStatus(1, 60000, "R4");
    check(attempts == 12, "R4", "attempts under cap", attempts, 12);
    bad = 0;
    for (int n = 1; n <= 11; n++) begin
      gap = startCyc[n + 1] - collCyc[n];
      k = (n < 10) ? n : 10;
      s = (gap - 14) / SLOT;
      if (gap < 14 || (gap - 14) % SLOT != 0 || s > (1 << k) - 1) bad++;
    end
    check(bad == 0, "R4", "capped gaps out of range", bad, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    testReset();
    testPlain();
    testPad();
    testFill(1'b0);
    testFill(1'b1);
    testDefer();
    testEnable();
    testRetry();
    testExcess(3);
    testExcess(0);
    testLate(1'b0, 19, 2, 1);
    testLate(1'b0, 20, 1, 3);
    testLate(1'b1, 25, 2, 1);
    testFullDuplex();
    testPause();
    testCap();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

endmodule